// File: doc/BRIEF.md
# Timer Prescaler and Interrupt Enable Register

This block is one byte-wide control register on a simple register bus, combined with the clock divider it configures. The upper four bits hold interrupt enables for four timer-related event sources. The lowest two bits choose how the divider scales the clock. The divider sends out a single-cycle count-enable pulse, which a downstream free-running timer counter uses to advance.

Each enable is paired with one status flag from a companion flag register. The block ANDs each flag with its enable and ORs the four results into a single interrupt request.

The prescaler field is protected in normal operation. It takes only one write, and that write must arrive within a short window after reset. Once the field is locked or the window has passed, writes leave it unchanged. When the mode input selects special operation, the field can be rewritten at any time. The enables can be written freely in both modes.

Top module: `tmr_presc_ctl`

## Requirements
- R1: After reset every readable bit is 0 and the divide ratio is 1.
- R2: With `sel` and `rd` both high, `rdata` shows the register in the same cycle: bits 7:4 are the enables and bits 1:0 are the prescaler select. At all other times `rdata` is 0.
- R3: Bits 3:2 always read 0, and a write to them has no effect.
- R4: A write sets all four enable bits (7:4) from `wdata`, in either mode and at any time.
- R5: The prescaler select sets the divide ratio: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 16. `tick` is a one-cycle pulse every N cycles, and at ratio 1 it stays high every cycle.
- R6: A write that changes the prescaler select restarts the divider from zero. The first `tick` comes in the Nth cycle after the write edge.
- R7: In normal mode (`special_mode`=0) the prescaler field is written only by the first write. That write must land on one of the first WINDOW (64) rising edges after reset is released. Every other write leaves the field unchanged.
- R8: In special mode (`special_mode`=1) every write updates the prescaler field, with no lock and no time limit.
- R9: `irq` is the OR of `flags[i]` AND enable bit 4+i, for i from 0 to 3. Flag 3 pairs with bit 7 and flag 0 pairs with bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | 1 selects special mode with an unrestricted prescaler field |
| sel | input | 1 | Register address decode |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| flags | input | 4 | Event flags from the companion flag register |
| rdata | output | 8 | Read data |
| tick | output | 1 | Prescaled count-enable pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default WINDOW of 64. This makes it cheap to sit at the last edge inside the window and the first edge outside it. For every divide ratio, the bench compares the tick pattern cycle by cycle against an expected pattern it computes from the ratio. It sweeps all 256 combinations of enable and flag values for the interrupt request.

// File: rtl/tmr_presc_ctl.sv
module tmr_presc_ctl #(
  parameter int WINDOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic [3:0] flags,
  output logic [7:0] rdata,
  output logic       tick,
  output logic       irq
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [3:0]    en_q;
  logic [1:0]    psel_q;
  logic          lock_q;
  logic [CW-1:0] win_cnt;
  logic [3:0]    div_cnt;
  logic [3:0]    div_last;

  wire wr_hit  = sel && wr;
  wire win_on  = (win_cnt < CW'(WINDOW));
  wire psel_ok = wr_hit && (special_mode || (!lock_q && win_on));
  wire restart = psel_ok && (wdata[1:0] != psel_q);

  always_comb begin
    case (psel_q)
      2'b00:   div_last = 4'd0;
      2'b01:   div_last = 4'd3;
      2'b10:   div_last = 4'd7;
      default: div_last = 4'd15;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      psel_q  <= '0;
      lock_q  <= 1'b0;
      win_cnt <= '0;
    end else begin
      if (win_on) win_cnt <= win_cnt + 1'b1;
      if (wr_hit) en_q <= wdata[7:4];
      if (psel_ok) begin
        psel_q <= wdata[1:0];
        lock_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick) div_cnt <= '0;
    else                           div_cnt <= div_cnt + 1'b1;
  end

  assign tick  = (div_cnt == div_last);
  assign irq   = |(flags & en_q);
  assign rdata = (sel && rd) ? {en_q, 2'b00, psel_q} : 8'h00;
endmodule

// File: rtl/tmr_presc_ctl_chk.sv
module tmr_presc_ctl_chk #(
  parameter int WINDOW = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       special_mode,
  input logic       sel,
  input logic       rd,
  input logic [3:0] flags,
  input logic [7:0] rdata,
  input logic       tick,
  input logic       irq,
  input logic [3:0] en_q,
  input logic [1:0] psel_q
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] edges;

  always_ff @(posedge clk) begin
    if (!rst_n) edges <= '0;
    else if (edges < CW'(WINDOW)) edges <= edges + 1'b1;
  end

  // R2
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |-> rdata == 8'h00);
  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3:2] == 2'b00);
  // R5
  ratio_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psel_q == 2'b00 |-> tick);
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_q != 2'b00 && psel_q != $past(psel_q)) |-> !tick);
  // R7
  window_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && edges >= CW'(WINDOW)) |=> psel_q == $past(psel_q));
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == 4'h0 |-> !irq);
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != 4'h0);
endmodule

bind tmr_presc_ctl tmr_presc_ctl_chk #(.WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .sel(sel), .rd(rd),
  .flags(flags), .rdata(rdata), .tick(tick), .irq(irq),
  .en_q(en_q), .psel_q(psel_q)
);

// File: tb/tmr_presc_ctl_bench.sv
module tmr_presc_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [3:0] flags = 4'h0;
  logic [7:0] rdata;
  logic       tick, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  tmr_presc_ctl #(.WINDOW(64)) u_tmr_presc_ctl (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .sel(sel), .rd(rd),
    .wr(wr), .wdata(wdata), .flags(flags), .rdata(rdata), .tick(tick), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 1'b0; special_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(logic [7:0] d);
    sel = 1'b1; wr = 1'b1; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic do_read(string req, logic [7:0] exp);
    sel = 1'b1; rd = 1'b1;
    #1 check(req, rdata, exp);
    sel = 1'b0; rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick_sweep(logic [1:0] ps);
    int n;
    int bad;
    n = (ps == 2'b00) ? 1 : (ps == 2'b01) ? 4 : (ps == 2'b10) ? 8 : 16;
    bad = 0;
    do_write({4'h0, 2'b00, ps});
    for (int i = 1; i <= 48; i++) begin
      if (tick !== ((i % n) == 0)) begin
        bad++;
        if (bad == 1)
          $display("FAIL R5/R6 ratio %0d cycle %0d actual=%b expected=%b",
                   n, i, tick, (i % n) == 0);
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    #1 check("R1 tick", {7'd0, tick}, 8'h01);
    check("R2 idle", rdata, 8'h00);
    @(negedge clk);
    do_read("R1 reset value", 8'h00);

    do_reset(1'b0);
    do_write(8'h02);
    do_read("R7 first write", 8'h02);
    do_write(8'h53);
    do_read("R7 lock / R4", 8'h52);

    do_reset(1'b0);
    repeat (63) @(negedge clk);
    do_write(8'h01);
    do_read("R7 last edge in window", 8'h01);

    do_reset(1'b0);
    repeat (64) @(negedge clk);
    do_write(8'h03);
    do_read("R7 first edge past window", 8'h00);
    do_write(8'hF0);
    do_read("R4 enables normal mode", 8'hF0);
    do_write(8'h0C);
    do_read("R3 pad write normal", 8'h00);

    do_reset(1'b1);
    tick_sweep(2'b01);
    tick_sweep(2'b10);
    tick_sweep(2'b11);
    tick_sweep(2'b00);
    tick_sweep(2'b11);
    tick_sweep(2'b01);
    repeat (100) @(negedge clk);
    do_write(8'h02);
    do_read("R8 late write special", 8'h02);
    do_write(8'h01);
    do_read("R8 rewrite special", 8'h01);
    do_write(8'hFF);
    do_read("R3 pad read", 8'hF3);
    do_write(8'h0C);
    do_read("R3 pad write", 8'h00);

    for (int e = 0; e < 16; e++) begin
      do_write({e[3:0], 4'h0});
      for (int f = 0; f < 16; f++) begin
        flags = f[3:0];
        #1 check($sformatf("R9 en=%h flags=%h", e[3:0], f[3:0]),
                 {7'd0, irq}, {7'd0, |(e[3:0] & f[3:0])});
        @(negedge clk);
      end
    end
    flags = 4'h0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule